// File: doc/BRIEF.md
# Floppy head seek sequencer

This block moves the read/write head of a floppy drive to a requested cylinder. It drives the drive's direction and step lines, keeps a record of the cylinder the head is on, and falls back to a recalibration run toward track zero whenever it cannot trust that record. All timing is counted in pulses of a one-microsecond time base (`us_tick`), so the block runs from any system clock faster than 1 MHz.

A seek is started with a one-cycle `seek_req` carrying `seek_cyl`. The block raises `busy`, issues the step pulses, waits a programmable settle time, then pulses `done` for one cycle with a result code on `status`. The gap after each step pulse (`step_gap_us`, 3000 us is a typical value) and the settle time (`settle_ms`, 15 ms is a typical value) are inputs. Drive select, motor control and command decoding are handled elsewhere.

Top module: `floppy_seek_seq`

## Requirements
- R1: After reset `dir_out`, `step_out`, `busy` and `done` are low and the head position is unknown, so the first seek always recalibrates.
- R2: For every step, `dir_out` is set at least 10 us ticks before `step_out` rises and does not change while `step_out` is high.
- R3: Every step pulse stays high for exactly 10 us ticks.
- R4: After a step pulse falls, at least `step_gap_us` plus 10 ticks pass before the next step pulse rises.
- R5: `dir_out` low moves the head outward (toward track zero); `dir_out` high moves it inward.
- R6: When the target is cylinder 0 or the position is unknown, the block steps outward until `trk0_n` reads low, then steps inward to the target.
- R7: If `trk0_n` is still high after 256 outward recalibration steps, the seek ends with `status` = 1 (no track zero) and the position becomes unknown, so the next seek recalibrates again.
- R8: With a known position and a non-zero target, the block issues exactly |target - current| steps, inward if the target is larger and outward if smaller, and none when they are equal.
- R9: A successful seek waits at least `settle_ms` times `US_PER_MS` ticks after its last step before `done`, reports `status` = 0, and records the target as the current cylinder.
- R10: A target above 85 is rejected: `done` pulses in the next cycle with `status` = 2, no step is issued and `busy` stays low.
- R11: A seek request that arrives while `busy` is high is ignored.
- R12: `done` is high for one cycle, only while `busy` is low, and `status` holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| seek_req | input | 1 | Start a seek (accepted only while not busy) |
| seek_cyl | input | 8 | Target cylinder |
| trk0_n | input | 1 | Track-zero sensor, low when the head is on cylinder 0 |
| step_gap_us | input | 16 | Wait after each step pulse, in microseconds |
| settle_ms | input | 8 | Settle time after the last step, in milliseconds |
| dir_out | output | 1 | Step direction, high = inward |
| step_out | output | 1 | Step pulse, active high |
| busy | output | 1 | A seek is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result: 0 success, 1 track zero not found, 2 cylinder out of range |

## Verification
The bench runs a drive model whose head starts on an unknown cylinder and walks a sequence of targets: a first seek that must recalibrate, inward and outward relative moves, a repeat of the current cylinder, an explicit seek to cylinder 0, the highest legal cylinder and the first illegal one. Comparing step counts per direction separates recalibration from relative motion and shows whether the recorded position is trusted. A drive whose track-zero sensor never asserts exposes the 256-step limit and the loss of position, and a second request injected mid-seek shows whether busy requests leak into the sequence. Pulse width, direction setup, inter-step gap and settle length are measured in microsecond ticks on every step.

// File: rtl/floppy_seek_pkg.sv
package floppy_seek_pkg;

  typedef enum logic [1:0] {
    SEEK_OK      = 2'd0,
    SEEK_NO_TRK0 = 2'd1,
    SEEK_BAD_CYL = 2'd2
  } seek_status_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HIGH  = 2'd2,
    PH_GAP   = 2'd3
  } step_phase_e;

  typedef enum logic [2:0] {
    SQ_IDLE       = 3'd0,
    SQ_RECAL      = 3'd1,
    SQ_RECAL_WAIT = 3'd2,
    SQ_MOVE       = 3'd3,
    SQ_MOVE_WAIT  = 3'd4,
    SQ_SETTLE     = 3'd5
  } seq_state_e;

endpackage

// File: rtl/floppy_step_gen.sv
module floppy_step_gen
  import floppy_seek_pkg::*;
#(
  parameter int GAP_W    = 16,
  parameter int SETUP_US = 10,
  parameter int PULSE_US = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             start,
  input  logic             dir_in,
  input  logic [GAP_W-1:0] gap_us,
  output logic             dir_out,
  output logic             step_out,
  output logic             idle,
  output logic             done
);

  localparam int CNT_W = (GAP_W > 8) ? GAP_W : 8;

  step_phase_e      ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             stp_q, stp_d;
  logic             done_q, done_d;
  logic             phase_end;
  logic             cnt_en;

  assign phase_end = (cnt_q == '0) || (us_tick && (cnt_q == CNT_W'(1)));
  assign cnt_en    = (ph_q != PH_IDLE) && !phase_end && us_tick;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    stp_d  = stp_q;
    done_d = 1'b0;
    if (cnt_en) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_SETUP;
          dir_d = dir_in;
          cnt_d = CNT_W'(SETUP_US);
        end
      end
      PH_SETUP: begin
        if (phase_end) begin
          ph_d  = PH_HIGH;
          stp_d = 1'b1;
          cnt_d = CNT_W'(PULSE_US);
        end
      end
      PH_HIGH: begin
        if (phase_end) begin
          ph_d  = PH_GAP;
          stp_d = 1'b0;
          cnt_d = CNT_W'(gap_us);
        end
      end
      PH_GAP: begin
        if (phase_end) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      stp_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      stp_q  <= stp_d;
      done_q <= done_d;
    end
  end

  assign dir_out  = dir_q;
  assign step_out = stp_q;
  assign idle     = (ph_q == PH_IDLE);
  assign done     = done_q;

  // R2: direction must not move while the pulse is high
  a_r2_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
    stp_q |-> $stable(dir_q));

  // R3: a pulse only begins at the end of the direction setup phase
  a_r3_rise_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stp_q) |-> ($past(ph_q) == PH_SETUP));

  // R4: completion is only reported after the gap phase
  a_r4_done_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(ph_q) == PH_GAP) && !stp_q);

endmodule

// File: rtl/floppy_settle_timer.sv
module floppy_settle_timer #(
  parameter int MS_W      = 8,
  parameter int US_PER_MS = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            us_tick,
  input  logic            start,
  input  logic [MS_W-1:0] ms_count,
  output logic            done
);

  localparam int PRE_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;

  logic             run_q, run_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic             done_q, done_d;
  logic             pre_wrap;
  logic             tick_en;

  assign pre_wrap = (pre_q == PRE_W'(US_PER_MS - 1));
  assign tick_en  = run_q && (ms_q != '0) && us_tick;

  always_comb begin
    run_d  = run_q;
    pre_d  = pre_q;
    ms_d   = ms_q;
    done_d = 1'b0;
    if (start) begin
      run_d = 1'b1;
      pre_d = '0;
      ms_d  = ms_count;
    end else if (run_q && (ms_q == '0)) begin
      run_d  = 1'b0;
      done_d = 1'b1;
    end else if (tick_en) begin
      if (pre_wrap) begin
        pre_d = '0;
        ms_d  = ms_q - MS_W'(1);
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      ms_q   <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      pre_q  <= pre_d;
      ms_q   <= ms_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  // R9: the settle done pulse only follows a running countdown
  a_r9_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(run_q) && !run_q);

endmodule

// File: rtl/floppy_seek_seq.sv
module floppy_seek_seq
  import floppy_seek_pkg::*;
#(
  parameter int CYL_W       = 8,
  parameter int MAX_CYL     = 85,
  parameter int RECAL_LIMIT = 256,
  parameter int SETUP_US    = 10,
  parameter int PULSE_US    = 10,
  parameter int GAP_W       = 16,
  parameter int SETTLE_W    = 8,
  parameter int US_PER_MS   = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                us_tick,
  input  logic                seek_req,
  input  logic [CYL_W-1:0]    seek_cyl,
  input  logic                trk0_n,
  input  logic [GAP_W-1:0]    step_gap_us,
  input  logic [SETTLE_W-1:0] settle_ms,
  output logic                dir_out,
  output logic                step_out,
  output logic                busy,
  output logic                done,
  output logic [1:0]          status
);

  localparam int RC_W = $clog2(RECAL_LIMIT + 1);

  seq_state_e       state_q, state_d;
  logic [CYL_W-1:0] cur_q, cur_d;
  logic             valid_q, valid_d;
  logic [CYL_W-1:0] tgt_q, tgt_d;
  logic [CYL_W-1:0] rem_q, rem_d;
  logic             mdir_q, mdir_d;
  logic [RC_W-1:0]  rc_q, rc_d;
  logic             done_q, done_d;
  seek_status_e     stat_q, stat_d;

  logic step_start, step_dir, step_idle, step_done;
  logic settle_start, settle_done;
  logic cyl_bad;

  assign cyl_bad = (seek_cyl > CYL_W'(MAX_CYL));

  floppy_step_gen #(
    .GAP_W    (GAP_W),
    .SETUP_US (SETUP_US),
    .PULSE_US (PULSE_US)
  ) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .start    (step_start),
    .dir_in   (step_dir),
    .gap_us   (step_gap_us),
    .dir_out  (dir_out),
    .step_out (step_out),
    .idle     (step_idle),
    .done     (step_done)
  );

  floppy_settle_timer #(
    .MS_W      (SETTLE_W),
    .US_PER_MS (US_PER_MS)
  ) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .start    (settle_start),
    .ms_count (settle_ms),
    .done     (settle_done)
  );

  always_comb begin
    state_d      = state_q;
    cur_d        = cur_q;
    valid_d      = valid_q;
    tgt_d        = tgt_q;
    rem_d        = rem_q;
    mdir_d       = mdir_q;
    rc_d         = rc_q;
    done_d       = 1'b0;
    stat_d       = stat_q;
    step_start   = 1'b0;
    step_dir     = mdir_q;
    settle_start = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (seek_req) begin
          if (cyl_bad) begin
            done_d = 1'b1;
            stat_d = SEEK_BAD_CYL;
          end else begin
            tgt_d = seek_cyl;
            rc_d  = '0;
            if ((seek_cyl == '0) || !valid_q) begin
              state_d = SQ_RECAL;
            end else begin
              state_d = SQ_MOVE;
              mdir_d  = (seek_cyl > cur_q);
              rem_d   = (seek_cyl > cur_q) ? (seek_cyl - cur_q) : (cur_q - seek_cyl);
            end
          end
        end
      end
      SQ_RECAL: begin
        if (!trk0_n) begin
          cur_d   = '0;
          valid_d = 1'b1;
          rem_d   = tgt_q;
          mdir_d  = 1'b1;
          state_d = SQ_MOVE;
        end else if (rc_q == RC_W'(RECAL_LIMIT)) begin
          valid_d = 1'b0;
          done_d  = 1'b1;
          stat_d  = SEEK_NO_TRK0;
          state_d = SQ_IDLE;
        end else if (step_idle) begin
          step_start = 1'b1;
          step_dir   = 1'b0;
          rc_d       = rc_q + RC_W'(1);
          state_d    = SQ_RECAL_WAIT;
        end
      end
      SQ_RECAL_WAIT: begin
        if (step_done) state_d = SQ_RECAL;
      end
      SQ_MOVE: begin
        if (rem_q == '0) begin
          settle_start = 1'b1;
          state_d      = SQ_SETTLE;
        end else if (step_idle) begin
          step_start = 1'b1;
          rem_d      = rem_q - CYL_W'(1);
          state_d    = SQ_MOVE_WAIT;
        end
      end
      SQ_MOVE_WAIT: begin
        if (step_done) state_d = SQ_MOVE;
      end
      SQ_SETTLE: begin
        if (settle_done) begin
          cur_d   = tgt_q;
          valid_d = 1'b1;
          done_d  = 1'b1;
          stat_d  = SEEK_OK;
          state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cur_q   <= '0;
      valid_q <= 1'b0;
      tgt_q   <= '0;
      rem_q   <= '0;
      mdir_q  <= 1'b0;
      rc_q    <= '0;
      done_q  <= 1'b0;
      stat_q  <= SEEK_OK;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      valid_q <= valid_d;
      tgt_q   <= tgt_d;
      rem_q   <= rem_d;
      mdir_q  <= mdir_d;
      rc_q    <= rc_d;
      done_q  <= done_d;
      stat_q  <= stat_d;
    end
  end

  assign busy   = (state_q != SQ_IDLE);
  assign done   = done_q;
  assign status = stat_q;

  // R10: out-of-range targets answer at once without starting a seek
  a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (seek_req && !busy && cyl_bad) |=> (done && (status == 2'd2) && !busy));

  // R12: completion is reported only once the block is idle
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11: no step activity outside a seek
  a_r11_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !step_out);

  // R6: recalibration steps always point outward
  a_r6_recal_outward: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SQ_RECAL_WAIT) && step_out) |-> !dir_out);

  // R7: recalibration never exceeds its step budget
  a_r7_recal_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rc_q <= RC_W'(RECAL_LIMIT));

endmodule

// File: tb/test_floppy_seek_seq.sv
module test_floppy_seek_seq;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 6;
  localparam int SETTLE     = 3;
  localparam int USMS       = 4;
  localparam int NVEC       = 8;

  typedef struct packed {
    int cyl;
    int n_in;
    int n_out;
    int st;
  } vec_t;

  // start head on cylinder 5 (unknown to the design)
  localparam vec_t VECS [NVEC] = '{
    '{10, 10, 5, 0},   // R1/R6 first seek recalibrates
    '{3, 0, 7, 0},     // R8 outward
    '{3, 0, 0, 0},     // R8 equal
    '{40, 37, 0, 0},   // R8 inward
    '{0, 0, 40, 0},    // R6 target zero
    '{85, 85, 0, 0},   // R10 highest legal
    '{86, 0, 0, 2},    // R10 rejected
    '{84, 0, 1, 0}     // R5 one outward
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       seek_req = 1'b0;
  logic [7:0] seek_cyl = '0;
  logic       trk0_n;
  logic       dir_out, step_out, busy, done;
  logic [1:0] status;

  int  total = 0, bad = 0;
  int  head = 5;
  bit  broken = 1'b0;
  int  n_in = 0, n_out = 0;
  int  t_dir = 1000, t_hi = 0, t_low = 1000, t_evt = 0;
  int  v_r2 = 0, v_r3 = 0, v_r4 = 0;
  bit  prev_step = 1'b0, prev_dir = 1'b0, tick_div = 1'b0;
  bit  mon_on = 1'b0;

  assign trk0_n = broken || (head != 0);

  always #(CLK_PERIOD/2) clk = ~clk;

  floppy_seek_seq #(.US_PER_MS(USMS)) i_floppy_seek_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .us_tick     (us_tick),
    .seek_req    (seek_req),
    .seek_cyl    (seek_cyl),
    .trk0_n      (trk0_n),
    .step_gap_us (16'(GAP)),
    .settle_ms   (8'(SETTLE)),
    .dir_out     (dir_out),
    .step_out    (step_out),
    .busy        (busy),
    .done        (done),
    .status      (status)
  );

  // drive model and waveform monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (dir_out != prev_dir) t_dir = 0;
      if (step_out && prev_step && (dir_out != prev_dir)) v_r2++;
      if (step_out && !prev_step) begin
        if (t_dir < 10) v_r2++;
        if (t_low < GAP + 10) v_r4++;
        t_hi = 0;
        if (dir_out) begin n_in++; head++; end
        else begin n_out++; if (head > 0) head--; end
      end
      if (!step_out && prev_step) begin
        if (t_hi != 10) v_r3++;
        t_low = 0;
        t_evt = 0;
      end
      tick_div = !tick_div;
      us_tick  = tick_div;
      if (us_tick) begin t_dir++; t_hi++; t_low++; t_evt++; end
      prev_step = step_out;
      prev_dir  = dir_out;
    end
  end

  task automatic chk(input bit ok, input string name, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", name, act, exp);
    end
  endtask

  task automatic issue(input int cyl);
    seek_cyl = 8'(cyl);
    seek_req = 1'b1;
    n_in = 0; n_out = 0; t_evt = 0;
    @(negedge clk);
    seek_req = 1'b0;
  endtask

  task automatic wait_done(output int st);
    while (done !== 1'b1) @(negedge clk);
    st = int'(status);
    chk(busy == 1'b0, "R12 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R12 done one cycle", int'(done), 0);
    chk(int'(status) == st, "R12 status held", int'(status), st);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int st;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dir_out == 1'b0, "R1 dir after reset", int'(dir_out), 0);
    chk(step_out == 1'b0, "R1 step after reset", int'(step_out), 0);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].cyl);
      if (VECS[i].st == 2)
        chk(done == 1'b1 && busy == 1'b0, "R10 immediate reject", int'(done), 1);
      wait_done(st);
      chk(st == VECS[i].st, $sformatf("R9/R10 status vec %0d", i), st, VECS[i].st);
      chk(n_in == VECS[i].n_in, $sformatf("R5/R8 inward steps vec %0d", i), n_in, VECS[i].n_in);
      chk(n_out == VECS[i].n_out, $sformatf("R6/R8 outward steps vec %0d", i), n_out, VECS[i].n_out);
      if (VECS[i].st == 0) begin
        chk(head == VECS[i].cyl, $sformatf("R9 head position vec %0d", i), head, VECS[i].cyl);
        chk(t_evt >= SETTLE * USMS, $sformatf("R9 settle ticks vec %0d", i), t_evt, SETTLE * USMS);
      end
      repeat (3) @(negedge clk);
    end

    // R11: second request during a seek is dropped
    issue(20);
    repeat (200) @(negedge clk);
    chk(busy == 1'b1, "R11 busy mid seek", int'(busy), 1);
    seek_cyl = 8'd0;
    seek_req = 1'b1;
    @(negedge clk);
    seek_req = 1'b0;
    wait_done(st);
    chk(st == 0, "R11 status", st, 0);
    chk(n_out == 64 && n_in == 0, "R11 step count", n_out, 64);
    chk(head == 20, "R11 head", head, 20);
    repeat (3) @(negedge clk);

    // R7: track zero never seen
    broken = 1'b1;
    issue(0);
    wait_done(st);
    chk(st == 1, "R7 status no track zero", st, 1);
    chk(n_out == 256, "R7 step budget", n_out, 256);
    chk(n_in == 0, "R7 no inward steps", n_in, 0);
    broken = 1'b0;
    repeat (3) @(negedge clk);
    // position now unknown: head is at 0, seek 7 must recalibrate then move in
    issue(7);
    wait_done(st);
    chk(st == 0, "R7 recovery status", st, 0);
    chk(n_in == 7 && n_out == 0, "R7 recovery steps", n_in, 7);
    chk(head == 7, "R7 recovery head", head, 7);

    chk(v_r2 == 0, "R2 direction setup and hold", v_r2, 0);
    chk(v_r3 == 0, "R3 pulse width", v_r3, 0);
    chk(v_r4 == 0, "R4 step gap", v_r4, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule